// File: doc/BRIEF.md
# Supply and Link Readiness Monitor

This block sits on the control side of a two-sided isolated gate driver. It decides whether the power switch may be driven, and it reports a non-latching ready status. It takes digitized undervoltage comparator flags from both supply domains. Each domain supplies one flag that is high above its power-up threshold and one that is high below its power-down threshold. From these it tracks a hysteresis state per supply.

A watchdog observes the heartbeat strobe coming out of the isolation link receiver. When that strobe stops for too long, the block declares an internal error and forces the gate off.

Ready is the AND of three conditions:
- the input-side supply state, taken directly;
- the output-side supply state, after a qualification delay;
- link health, after its own qualification delay.

Ready therefore needs no clearing. It rises again by itself once all three conditions are restored. The gate lockout output uses the unqualified states, so a fault switches the gate off without waiting for any qualification.

Top module: `supply_link_guard`

## Requirements
- R1: While reset is asserted and before any clock edge after its release, ready is 0, gateLockout is 1 and linkError is 1.
- R2: A supply becomes good only at a clock edge where its upper flag is 1. It stays good at edges where both flags are 0. It becomes bad only at an edge where its lower flag is 1, and once bad it stays bad until its upper flag is seen again.
- R3: gateLockout is 1 whenever the input-side or the output-side supply is bad.
- R4: At the clock edge where the input-side lower flag is sampled high, gateLockout rises and ready falls together. When the input side recovers, ready returns at the same edge with no qualification delay, provided the other two conditions are already qualified.
- R5: The output-side supply counts toward ready only after it has been good for OUT_DLY further clock edges. Losing it drops ready at once.
- R6: A heartbeat strobe sampled high reloads the watchdog to WD_TIMEOUT. linkError rises at the WD_TIMEOUT-th consecutive edge without a strobe. Strobes spaced WD_TIMEOUT edges apart never raise linkError.
- R7: While linkError is 1, gateLockout is 1 and ready is 0.
- R8: linkError clears at the first edge that samples a strobe. Link health then counts toward ready only after LINK_DLY further edges with strobes arriving.
- R9: ready is 1 exactly when the input supply is good, the output supply is qualified and the link is qualified. It is never latched and never needs a reset to return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inAboveHi | input | 1 | Input-side supply above power-up threshold |
| inBelowLo | input | 1 | Input-side supply below power-down threshold |
| outAboveHi | input | 1 | Output-side supply above power-up threshold |
| outBelowLo | input | 1 | Output-side supply below power-down threshold |
| linkValid | input | 1 | One-cycle heartbeat strobe from the link receiver |
| ready | output | 1 | Non-latching ready status |
| gateLockout | output | 1 | Forces the gate off when high |
| linkError | output | 1 | Watchdog expired, internal transmission error |

## Verification
The assertions assume that a comparator pair never reports a supply as both above its upper threshold and below its lower one in the same cycle. The stimulus encodes each supply as exactly one of three levels: high, between thresholds, or low. It therefore never drives both flags of a pair high. The assertions also assume the heartbeat is a level that is sampled at each edge. The bench drives strobes as one-cycle pulses or as a held level, and changes them only at falling clock edges.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int NUM_SUP = 2;
  localparam int SUP_IN  = 0;
  localparam int SUP_OUT = 1;

  // control -> datapath strobes
  typedef struct packed {
    logic outRun;    // output supply currently good
    logic wdReload;  // heartbeat seen this cycle
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic outQual;   // output supply good long enough
    logic linkAlive; // watchdog not expired
    logic linkQual;  // link alive long enough
  } dpStatus_t;
endpackage

// File: rtl/guard_hyst.sv
module guard_hyst (
  input  logic clk,
  input  logic rstN,
  input  logic aboveHi,
  input  logic belowLo,
  output logic good
);
  always_ff @(posedge clk) begin
    if (!rstN)        good <= 1'b0;
    else if (good)    begin if (belowLo) good <= 1'b0; end
    else if (aboveHi) good <= 1'b1;
  end

  // input assumption: a comparator pair is never contradictory
  p_flags_sane_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(aboveHi && belowLo));
  p_rise_on_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(good) |-> $past(aboveHi));
  p_fall_on_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(good) |-> $past(belowLo));
endmodule

// File: rtl/guard_qual.sv
module guard_qual #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic src,
  output logic qual
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] CMAX = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (!src)        cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign qual = src && (cnt == CMAX);

  p_qual_after_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qual) |-> $past(src));
endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int OUT_DLY    = 4,
  parameter int LINK_DLY   = 3,
  parameter int WD_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int WW = $clog2(WD_TIMEOUT + 1);
  localparam logic [WW-1:0] WD_LOAD = WW'(WD_TIMEOUT);

  logic [WW-1:0] wdCnt;
  logic          alive;
  logic [1:0]    qSrc;
  logic [1:0]    qOut;

  always_ff @(posedge clk) begin
    if (!rstN)                wdCnt <= '0;
    else if (strobe.wdReload) wdCnt <= WD_LOAD;
    else if (wdCnt != '0)     wdCnt <= wdCnt - 1'b1;
  end

  assign alive   = (wdCnt != '0);
  assign qSrc[0] = strobe.outRun;
  assign qSrc[1] = alive;

  for (genvar g = 0; g < 2; g++) begin : g_qual
    guard_qual #(.DLY(g == 0 ? OUT_DLY : LINK_DLY)) u_qual (
      .clk (clk),
      .rstN(rstN),
      .src (qSrc[g]),
      .qual(qOut[g])
    );
  end

  assign status.outQual   = qOut[0];
  assign status.linkAlive = alive;
  assign status.linkQual  = qOut[1];

  p_reload_alive_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wdReload |=> status.linkAlive);
  p_expire_no_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status.linkAlive) |-> !$past(strobe.wdReload));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] aboveHi,
  input  logic [1:0] belowLo,
  input  logic       linkValid,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       gateLockout,
  output logic       linkError
);
  logic [NUM_SUP-1:0] supGood;

  for (genvar s = 0; s < NUM_SUP; s++) begin : g_sup
    guard_hyst u_hyst (
      .clk    (clk),
      .rstN   (rstN),
      .aboveHi(aboveHi[s]),
      .belowLo(belowLo[s]),
      .good   (supGood[s])
    );
  end

  assign strobe.outRun   = supGood[SUP_OUT];
  assign strobe.wdReload = linkValid;

  assign linkError   = !status.linkAlive;
  assign gateLockout = !supGood[SUP_IN] || !supGood[SUP_OUT] || linkError;
  assign ready       = supGood[SUP_IN] && status.outQual && status.linkQual;

  p_ready_unlocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !gateLockout);
  p_in_drop_now_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(belowLo[SUP_IN]) |-> (gateLockout && !ready));
  p_err_forces_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkError |-> (gateLockout && !ready));
  p_out_bad_locks_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(belowLo[SUP_OUT]) |-> gateLockout);
endmodule

// File: rtl/supply_link_guard.sv
module supply_link_guard
  import guard_pkg::*;
#(
  parameter int OUT_DLY    = 4,
  parameter int LINK_DLY   = 3,
  parameter int WD_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic inAboveHi,
  input  logic inBelowLo,
  input  logic outAboveHi,
  input  logic outBelowLo,
  input  logic linkValid,
  output logic ready,
  output logic gateLockout,
  output logic linkError
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic [1:0] aboveHi;
  logic [1:0] belowLo;

  assign aboveHi[SUP_IN]  = inAboveHi;
  assign aboveHi[SUP_OUT] = outAboveHi;
  assign belowLo[SUP_IN]  = inBelowLo;
  assign belowLo[SUP_OUT] = outBelowLo;

  guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .aboveHi    (aboveHi),
    .belowLo    (belowLo),
    .linkValid  (linkValid),
    .status     (status),
    .strobe     (strobe),
    .ready      (ready),
    .gateLockout(gateLockout),
    .linkError  (linkError)
  );

  guard_dp #(
    .OUT_DLY   (OUT_DLY),
    .LINK_DLY  (LINK_DLY),
    .WD_TIMEOUT(WD_TIMEOUT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .status(status)
  );
endmodule

// File: tb/tb_supply_link_guard.sv
`timescale 1ns/1ps
module tb_supply_link_guard;
  localparam int OUT_DLY    = 4;
  localparam int LINK_DLY   = 3;
  localparam int WD_TIMEOUT = 16;

  logic clk = 1'b0;
  logic rstN;
  logic inHi, inLo, outHi, outLo, valid;
  logic ready, gateLockout, linkError;
  int   nRun  = 0;
  int   nFail = 0;

  always #10 clk = ~clk;

  supply_link_guard #(
    .OUT_DLY(OUT_DLY), .LINK_DLY(LINK_DLY), .WD_TIMEOUT(WD_TIMEOUT)
  ) dut (
    .clk(clk), .rstN(rstN),
    .inAboveHi(inHi), .inBelowLo(inLo),
    .outAboveHi(outHi), .outBelowLo(outLo),
    .linkValid(valid),
    .ready(ready), .gateLockout(gateLockout), .linkError(linkError)
  );

  // {inHi,inLo,outHi,outLo,valid, expReady,expLock,expErr}
  localparam logic [7:0] VEC [13] = '{
    8'b10101_000, // R2 both rise, link alive
    8'b00001_000, // R2 hold between thresholds
    8'b00001_000,
    8'b00001_000, // R8 link qualified, output not yet
    8'b00001_100, // R5 output qualified -> ready
    8'b01001_010, // R4 input drop, immediate
    8'b10001_100, // R4 input recovers, no delay
    8'b00011_010, // R5 output drop, immediate
    8'b00101_000, // R3 output good, unqualified
    8'b00001_000,
    8'b00001_000,
    8'b00001_000,
    8'b00001_100  // R9 ready returns without reset
  };

  task automatic check(input string tag, input logic got, input logic exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag, input logic eR, input logic eL, input logic eE);
    check({tag, " ready"}, ready, eR);
    check({tag, " gateLockout"}, gateLockout, eL);
    check({tag, " linkError"}, linkError, eE);
  endtask

  // wait one rising edge and sample just after it
  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: bench hung");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; inHi = 0; inLo = 0; outHi = 0; outLo = 0; valid = 0;
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 in reset", 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkAll("R1 after release", 1'b0, 1'b1, 1'b1);

    // vector table
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      {inHi, inLo, outHi, outLo, valid} = VEC[i][7:3];
      edge1();
      checkAll($sformatf("R9 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R2: input stays locked between thresholds until upper flag
    @(negedge clk); inHi = 0; inLo = 1;
    edge1(); checkAll("R2 in low", 1'b0, 1'b1, 1'b0);
    @(negedge clk); inLo = 0;
    for (int k = 0; k < 3; k++) begin
      edge1(); checkAll("R2 in hold bad", 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk); inHi = 1;
    edge1(); checkAll("R2 in good again", 1'b1, 1'b0, 1'b0);
    @(negedge clk); inHi = 0;

    // R6/R7: watchdog expiry after WD_TIMEOUT edges without strobe
    valid = 0;
    for (int k = 0; k < WD_TIMEOUT - 1; k++) edge1();
    checkAll("R6 just before expiry", 1'b1, 1'b0, 1'b0);
    edge1();
    checkAll("R7 expired", 1'b0, 1'b1, 1'b1);

    // R8: recovery on strobe, ready after LINK_DLY
    @(negedge clk); valid = 1;
    edge1();
    checkAll("R8 error cleared", 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < LINK_DLY - 1; k++) edge1();
    checkAll("R8 link not yet qualified", 1'b0, 1'b0, 1'b0);
    edge1();
    checkAll("R8 link qualified", 1'b1, 1'b0, 1'b0);

    // R6: strobes exactly WD_TIMEOUT apart never expire
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); valid = 1;
      edge1(); check("R6 periodic linkError", linkError, 1'b0);
      @(negedge clk); valid = 0;
      for (int k = 0; k < WD_TIMEOUT - 1; k++) begin
        edge1(); check("R6 periodic linkError", linkError, 1'b0);
      end
    end
    edge1();
    checkAll("R6 one edge late expires", 1'b0, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule